// File: doc/BRIEF.md
# Flash Command Controller

This block is the register front end of an on-chip flash memory. A 32-bit bus slave sees six word registers: a mode register, a command register, a status register, a page buffer port, an array pointer and an array data port. Software fills the page buffer, then writes a keyed command word. The controller checks the key, the opcode and the page or bit index, and checks the target against the sector lock bits. If all checks pass it runs the operation for a set number of busy cycles. If a check fails it aborts and raises an error flag.

The operations are page write, erase of the whole array, sector lock and unlock, set and clear of a general-purpose non-volatile bit, and setting of the security bit. The array is a plain word memory. A page write copies the buffer into it, and an erase fills it with ones. Busy time is a base parameter plus a cycle field in the mode register. A build option reports the end of lock commands through a separate end-of-lock flag and keeps the ready flag high during those commands.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, status reads 0x00000001, mode reads 0 and every array word reads 0xFFFFFFFF.
- R2: The mode register keeps only its cycle field (bits 23:16) and its wait-state bit (bit 8). All its other bits read as zero.
- R3: A command word carries the key 0x5A in bits 31:24, a page number in bits 17:8 and the opcode in bits 7:0. A valid command drops ready (status bit 0) for exactly BUSY_BASE plus the mode cycle field cycles, counted from the cycle after the write.
- R4: The command aborts with ready held high and sets the key error flag (status bit 3) in any of these cases: a wrong key, an unknown opcode, a page number of PAGES or more on a page or lock command, or a bit index of NVM_BITS or more on a non-volatile bit command.
- R5: The command aborts and sets the lock error flag (status bit 2) in two cases: a page write to a page inside a locked sector, or an erase-all while any sector is locked.
- R6: A status read returns the error flags and then clears both of them. The next read shows them low.
- R7: Page write (opcode 0x01) copies the page buffer into words page*PAGE_WORDS onward when the busy time ends. The array keeps its old contents while busy. Buffer writes advance a slot index that wraps at PAGE_WORDS, and the index returns to slot 0 after a page write.
- R8: Erase-all (opcode 0x08) sets every array word to 0xFFFFFFFF.
- R9: Lock (0x02) and unlock (0x04) set or clear status bit 16+s, where s is the page number divided by PAGES_PER_SECTOR.
- R10: Non-volatile bit set (0x0B) and clear (0x0D) use the page field as a bit index i and change status bit 8+i.
- R11: Opcode 0x0F sets the security bit (status bit 4), which then stays set.
- R12: While busy, command writes and page buffer writes have no effect. This includes a write in the last busy cycle: it raises no flag and changes no state.
- R13: With LOCK_VIA_EOL=1, lock and unlock commands keep ready high. The end-of-lock flag (status bit 1) clears when such a command is accepted and sets when it completes. With the default of 0, status bit 1 stays low.
- R14: Word addresses: 0 mode, 1 command, 2 status, 3 page buffer, 4 array pointer, 5 array data (the word at the pointer). The command and page buffer addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |

## Verification
The busy counter can expire in the same cycle that a new command word arrives. When that happens the controller must still count as busy and drop the command, and ready must rise in the next cycle. The bench counts cycles from the accepting write and issues a lock command in exactly the last busy cycle. It then judges the result on the next status read: ready is high, the lock bits are unchanged and both error flags are clear. A page buffer write inside the same busy window is checked the same way. A later page write has to show the buffer contents written before the window, starting at slot 0.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  localparam logic [7:0] CMD_KEY = 8'h5A;
  localparam int         REG_AW  = 3;

  localparam logic [REG_AW-1:0] A_MODE   = 3'd0;
  localparam logic [REG_AW-1:0] A_CMD    = 3'd1;
  localparam logic [REG_AW-1:0] A_STATUS = 3'd2;
  localparam logic [REG_AW-1:0] A_PBUF   = 3'd3;
  localparam logic [REG_AW-1:0] A_APTR   = 3'd4;
  localparam logic [REG_AW-1:0] A_ADATA  = 3'd5;

  typedef enum logic [7:0] {
    OP_PAGE_WR  = 8'h01,
    OP_LOCK_SET = 8'h02,
    OP_LOCK_CLR = 8'h04,
    OP_ERASE    = 8'h08,
    OP_NVM_SET  = 8'h0B,
    OP_NVM_CLR  = 8'h0D,
    OP_SEC_SET  = 8'h0F
  } op_e;

  // sector that holds a page
  function automatic logic [9:0] sector_of(input logic [9:0] page, input int pps);
    return 10'(int'(page) / pps);
  endfunction

  // first array word of a page
  function automatic int page_base(input logic [9:0] page, input int pw);
    return int'(page) * pw;
  endfunction

  // busy duration in cycles
  function automatic logic [8:0] busy_len(input logic [7:0] base, input logic [7:0] fld);
    return 9'(base) + 9'(fld);
  endfunction

  function automatic logic op_known(input logic [7:0] op);
    case (op)
      OP_PAGE_WR, OP_LOCK_SET, OP_LOCK_CLR, OP_ERASE,
      OP_NVM_SET, OP_NVM_CLR, OP_SEC_SET: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_lock(input logic [7:0] op);
    return (op == OP_LOCK_SET) || (op == OP_LOCK_CLR);
  endfunction

endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
  import fcc_pkg::*;
#(
  parameter int SECTORS          = 16,
  parameter int PAGES_PER_SECTOR = 4,
  parameter int NVM_BITS         = 3
) (
  input  logic [7:0]         key,
  input  logic [9:0]         page,
  input  logic [7:0]         op,
  input  logic [SECTORS-1:0] lock_bits,
  output logic               bad,
  output logic               locked
);
  localparam int PAGES = SECTORS * PAGES_PER_SECTOR;
  localparam int SW    = (SECTORS > 1) ? $clog2(SECTORS) : 1;

  logic          page_range_bad;
  logic          nvm_range_bad;
  logic [SW-1:0] sec;

  assign sec = SW'(sector_of(page, PAGES_PER_SECTOR));

  always_comb begin
    page_range_bad = 1'b0;
    nvm_range_bad  = 1'b0;
    case (op)
      OP_PAGE_WR, OP_LOCK_SET, OP_LOCK_CLR: page_range_bad = (int'(page) >= PAGES);
      OP_NVM_SET, OP_NVM_CLR:               nvm_range_bad  = (int'(page) >= NVM_BITS);
      default: ;
    endcase
  end

  assign bad = (key != CMD_KEY) || !op_known(op) || page_range_bad || nvm_range_bad;

  always_comb begin
    locked = 1'b0;
    if (op == OP_PAGE_WR) locked = lock_bits[sec];
    if (op == OP_ERASE)   locked = |lock_bits;
  end

endmodule

// File: rtl/fcc_timer.sv
module fcc_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= len - 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r12_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/fcc_store.sv
module fcc_store #(
  parameter int WORDS      = 256,
  parameter int PAGE_WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pbuf_we,
  input  logic [31:0]              pbuf_wdata,
  input  logic                     commit_page,
  input  logic [$clog2(WORDS)-1:0] commit_base,
  input  logic                     erase_all,
  input  logic [$clog2(WORDS)-1:0] rd_addr,
  output logic [31:0]              rd_data
);
  localparam int AW  = $clog2(WORDS);
  localparam int PIW = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;

  logic [31:0]                   mem [WORDS];
  logic [PIW-1:0]                slot_idx;
  logic [PAGE_WORDS-1:0][31:0]   slot_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   slot_idx <= '0;
    else if (commit_page)                         slot_idx <= '0;
    else if (pbuf_we) begin
      if (int'(slot_idx) == PAGE_WORDS - 1)       slot_idx <= '0;
      else                                        slot_idx <= slot_idx + 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_slot
    logic [31:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 q <= '0;
      else if (pbuf_we && int'(slot_idx) == g)    q <= pbuf_wdata;
    end
    assign slot_flat[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (erase_all) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (commit_page) begin
      for (int w = 0; w < PAGE_WORDS; w++) mem[commit_base + AW'(w)] <= slot_flat[w];
    end
  end

  assign rd_data = mem[rd_addr];

  a_r7_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_page && (erase_all || pbuf_we)));
  a_r7_index_home: assert property (@(posedge clk) disable iff (!rst_n)
    commit_page |=> (slot_idx == '0));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int SECTORS          = 16,
  parameter int PAGES_PER_SECTOR = 4,
  parameter int PAGE_WORDS       = 4,
  parameter int NVM_BITS         = 3,
  parameter int BUSY_BASE        = 4,
  parameter bit LOCK_VIA_EOL     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int PAGES = SECTORS * PAGES_PER_SECTOR;
  localparam int WORDS = PAGES * PAGE_WORDS;
  localparam int AW    = $clog2(WORDS);
  localparam int SW    = (SECTORS > 1) ? $clog2(SECTORS) : 1;
  localparam int NIW   = (NVM_BITS > 1) ? $clog2(NVM_BITS) : 1;

  // register state
  logic [7:0]          mode_cyc;
  logic                mode_ws;
  logic [SECTORS-1:0]  lock_bits;
  logic [NVM_BITS-1:0] nvm_bits;
  logic                sec_bit;
  logic                lock_err;
  logic                key_err;
  logic                eol_flag;
  logic [AW-1:0]       arr_ptr;
  logic [7:0]          pend_op;
  logic [9:0]          pend_page;

  // named events
  logic        cmd_wr, stat_rd, pbuf_we;
  logic        cmd_bad, cmd_locked, cmd_accept;
  logic        busy, op_done, ready;
  logic        pend_lock, lock_quiet;
  logic [31:0] status_word, arr_rd;
  logic [SW-1:0] pend_sec;

  assign cmd_wr     = bus_sel && bus_wr  && (bus_addr == A_CMD);
  assign stat_rd    = bus_sel && !bus_wr && (bus_addr == A_STATUS);
  assign pbuf_we    = bus_sel && bus_wr  && (bus_addr == A_PBUF) && !busy;
  assign cmd_accept = cmd_wr && !busy && !cmd_bad && !cmd_locked;

  fcc_decode #(
    .SECTORS(SECTORS), .PAGES_PER_SECTOR(PAGES_PER_SECTOR), .NVM_BITS(NVM_BITS)
  ) u_decode (
    .key(bus_wdata[31:24]), .page(bus_wdata[17:8]), .op(bus_wdata[7:0]),
    .lock_bits(lock_bits), .bad(cmd_bad), .locked(cmd_locked)
  );

  fcc_timer #(.CNT_W(9)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(cmd_accept),
    .len(busy_len(8'(BUSY_BASE), mode_cyc)), .busy(busy), .done(op_done)
  );

  fcc_store #(.WORDS(WORDS), .PAGE_WORDS(PAGE_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .pbuf_we(pbuf_we), .pbuf_wdata(bus_wdata),
    .commit_page(op_done && pend_op == OP_PAGE_WR),
    .commit_base(AW'(page_base(pend_page, PAGE_WORDS))),
    .erase_all(op_done && pend_op == OP_ERASE),
    .rd_addr(arr_ptr), .rd_data(arr_rd)
  );

  assign pend_lock  = op_is_lock(pend_op);
  assign lock_quiet = LOCK_VIA_EOL && pend_lock;
  assign ready      = !(busy && !lock_quiet);
  assign pend_sec   = SW'(sector_of(pend_page, PAGES_PER_SECTOR));

  // mode, pointer and pending command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_cyc  <= '0;
      mode_ws   <= 1'b0;
      arr_ptr   <= '0;
      pend_op   <= '0;
      pend_page <= '0;
    end else begin
      if (bus_sel && bus_wr && bus_addr == A_MODE) begin
        mode_cyc <= bus_wdata[23:16];
        mode_ws  <= bus_wdata[8];
      end
      if (bus_sel && bus_wr && bus_addr == A_APTR) arr_ptr <= bus_wdata[AW-1:0];
      if (cmd_accept) begin
        pend_op   <= bus_wdata[7:0];
        pend_page <= bus_wdata[17:8];
      end
    end
  end

  // error flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_err <= 1'b0;
      key_err  <= 1'b0;
    end else if (stat_rd) begin
      lock_err <= 1'b0;
      key_err  <= 1'b0;
    end else if (cmd_wr && !busy) begin
      if (cmd_bad)         key_err  <= 1'b1;
      else if (cmd_locked) lock_err <= 1'b1;
    end
  end

  // non-volatile state, applied when the busy time ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_bits <= '0;
      nvm_bits  <= '0;
      sec_bit   <= 1'b0;
    end else if (op_done) begin
      case (pend_op)
        OP_LOCK_SET: lock_bits[pend_sec]             <= 1'b1;
        OP_LOCK_CLR: lock_bits[pend_sec]             <= 1'b0;
        OP_NVM_SET:  nvm_bits[pend_page[NIW-1:0]]    <= 1'b1;
        OP_NVM_CLR:  nvm_bits[pend_page[NIW-1:0]]    <= 1'b0;
        OP_SEC_SET:  sec_bit                         <= 1'b1;
        default: ;
      endcase
    end
  end

  // end-of-lock flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                                    eol_flag <= 1'b0;
    else if (LOCK_VIA_EOL && cmd_accept && op_is_lock(bus_wdata[7:0])) eol_flag <= 1'b0;
    else if (op_done && lock_quiet)                                eol_flag <= 1'b1;
  end

  assign status_word = {16'(lock_bits), 8'(nvm_bits), 3'b000, sec_bit,
                        key_err, lock_err, eol_flag, ready};

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_MODE:   bus_rdata = {8'h00, mode_cyc, 7'h00, mode_ws, 8'h00};
        A_STATUS: bus_rdata = status_word;
        A_APTR:   bus_rdata = 32'(arr_ptr);
        A_ADATA:  bus_rdata = arr_rd;
        default:  bus_rdata = '0;
      endcase
    end
  end

  a_r3_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> busy);
  a_r4_bad_flags_key: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && cmd_bad) |=> (key_err && !busy));
  a_r5_locked_flags_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !cmd_bad && cmd_locked) |=> (lock_err && !busy));
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (!lock_err && !key_err));
  a_r9_locks_change_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !op_done |=> $stable(lock_bits));
  a_r11_security_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sec_bit |=> sec_bit);
  a_r12_busy_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> ($stable(lock_err) && $stable(key_err) && $stable(pend_op)));
  a_r13_eol_on_lock_end: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && pend_lock) |=> (eol_flag == LOCK_VIA_EOL));

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bsel = 1'b0, bwr = 1'b0;
  logic [2:0]  baddr = '0;
  logic [31:0] bwdata = '0;
  logic [31:0] rdata, rdata_e;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_sel(bsel), .bus_wr(bwr),
    .bus_addr(baddr), .bus_wdata(bwdata), .bus_rdata(rdata));
  flash_cmd_ctrl #(.LOCK_VIA_EOL(1'b1)) dut_eol (.clk(clk), .rst_n(rst_n), .bus_sel(bsel),
    .bus_wr(bwr), .bus_addr(baddr), .bus_wdata(bwdata), .bus_rdata(rdata_e));

  typedef struct { logic [31:0] e0; logic [31:0] e1; string tag; } item_t;
  item_t sb[$];
  int vectors = 0, miscmp = 0;
  bit fin = 1'b0;

  // bench model
  logic [31:0] m_mem [256];
  logic [31:0] m_pbuf [4];
  int          m_pidx = 0;
  logic [15:0] m_lock = '0;
  logic [2:0]  m_nvm = '0;
  logic        m_sec = 1'b0, m_eol = 1'b0;
  int          m_cyc = 0;

  function automatic int nbusy();
    return 4 + m_cyc;
  endfunction

  function automatic logic [31:0] stat(input logic rdy, input logic eol,
                                       input logic le, input logic ke);
    return {m_lock, 5'b0, m_nvm, 3'b0, m_sec, ke, le, eol, rdy};
  endfunction

  function automatic logic [31:0] cmdw(input logic [7:0] key, input int page,
                                       input logic [7:0] op);
    return {key, 6'b0, 10'(page), op};
  endfunction

  // monitor: compares reads against the scoreboard
  always @(negedge clk) begin
    if (rst_n && bsel && !bwr) begin
      item_t it;
      if (sb.size() == 0) begin
        miscmp++;
        $display("FAIL scoreboard empty (R14) actual=%h expected=none", rdata);
      end else begin
        it = sb.pop_front();
        vectors += 2;
        if (rdata !== it.e0) begin
          miscmp++;
          $display("FAIL %s dut actual=%h expected=%h", it.tag, rdata, it.e0);
        end
        if (rdata_e !== it.e1) begin
          miscmp++;
          $display("FAIL %s dut_eol actual=%h expected=%h", it.tag, rdata_e, it.e1);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bsel = 1'b1; bwr = 1'b1; baddr = a; bwdata = d;
    @(posedge clk); #1;
    bsel = 1'b0; bwr = 1'b0;
  endtask

  task automatic rd2(input logic [2:0] a, input logic [31:0] e0, input logic [31:0] e1,
                     input string tag);
    item_t it;
    it.e0 = e0; it.e1 = e1; it.tag = tag;
    sb.push_back(it);
    bsel = 1'b1; bwr = 1'b0; baddr = a;
    @(posedge clk); #1;
    bsel = 1'b0;
  endtask

  task automatic st(input logic r0, input logic r1, input logic e1, input logic le,
                    input logic ke, input string tag);
    rd2(3'd2, stat(r0, 1'b0, le, ke), stat(r1, e1, le, ke), tag);
  endtask

  task automatic chk_word(input int idx, input string tag);
    wr(3'd4, 32'(idx));
    rd2(3'd5, m_mem[idx], m_mem[idx], tag);
  endtask

  task automatic pb(input logic [31:0] d);
    wr(3'd3, d);
    m_pbuf[m_pidx] = d;
    m_pidx = (m_pidx + 1) % 4;
  endtask

  // valid command with model update and full busy wait
  task automatic do_cmd(input logic [7:0] op, input int page);
    int n;
    n = nbusy();
    wr(3'd1, cmdw(8'h5A, page, op));
    idle(n);
    case (op)
      8'h01: begin
        for (int w = 0; w < 4; w++) m_mem[page*4 + w] = m_pbuf[w];
        m_pidx = 0;
      end
      8'h02: begin m_lock[page/4] = 1'b1; m_eol = 1'b1; end
      8'h04: begin m_lock[page/4] = 1'b0; m_eol = 1'b1; end
      8'h08: for (int i = 0; i < 256; i++) m_mem[i] = '1;
      8'h0B: m_nvm[page] = 1'b1;
      8'h0D: m_nvm[page] = 1'b0;
      8'h0F: m_sec = 1'b1;
      default: ;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      miscmp++;
      $display("FAIL watchdog (R3 completion) actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = '1;
    for (int i = 0; i < 4; i++) m_pbuf[i] = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state, R14 map
    st(1, 1, 0, 0, 0, "R1 status after reset");
    rd2(3'd0, 32'h0, 32'h0, "R1 mode after reset");
    chk_word(0, "R1 array erased after reset");
    chk_word(255, "R1 last word erased after reset");
    rd2(3'd1, 32'h0, 32'h0, "R14 command address reads zero");

    // R2 mode fields
    wr(3'd0, 32'hFFFF_FFFF);
    rd2(3'd0, 32'h00FF_0100, 32'h00FF_0100, "R2 mode keeps only its fields");
    wr(3'd0, 32'h0);

    // R7 page write, array unchanged while busy, R3 busy
    pb(32'hA000_0000); pb(32'hA000_0001); pb(32'hA000_0002); pb(32'hA000_0003);
    wr(3'd1, cmdw(8'h5A, 5, 8'h01));
    st(0, 0, 0, 0, 0, "R3 ready low after page write");
    wr(3'd4, 32'd20);
    rd2(3'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 array unchanged while busy");
    idle(1);
    for (int w = 0; w < 4; w++) m_mem[20 + w] = m_pbuf[w];
    m_pidx = 0;
    st(1, 1, 0, 0, 0, "R3 ready back after 4 cycles");
    for (int w = 0; w < 4; w++) chk_word(20 + w, "R7 page written");

    // R3 busy length with mode field, R10 nvm set
    wr(3'd0, 32'h0003_0000);
    m_cyc = 3;
    wr(3'd1, cmdw(8'h5A, 1, 8'h0B));
    for (int c = 0; c < 7; c++) st(0, 0, m_eol, 0, 0, "R3 busy through 7 cycles");
    m_nvm[1] = 1'b1;
    st(1, 1, m_eol, 0, 0, "R3 R10 ready after 7 cycles with nvm bit 1");
    wr(3'd0, 32'h0);
    m_cyc = 0;

    // R4 bad commands, R6 read clears
    wr(3'd1, cmdw(8'h5B, 0, 8'h01));
    st(1, 1, m_eol, 0, 1, "R4 wrong key sets key error");
    st(1, 1, m_eol, 0, 0, "R6 key error cleared by read");
    wr(3'd1, cmdw(8'h5A, 0, 8'h03));
    st(1, 1, m_eol, 0, 1, "R4 unknown opcode");
    wr(3'd1, cmdw(8'h5A, 64, 8'h01));
    st(1, 1, m_eol, 0, 1, "R4 page out of range");
    wr(3'd1, cmdw(8'h5A, 3, 8'h0B));
    st(1, 1, m_eol, 0, 1, "R4 nvm index out of range");

    // R9 lock, R5 lock errors
    do_cmd(8'h02, 9);
    st(1, 1, m_eol, 0, 0, "R9 lock page 9 sets sector 2 bit");
    wr(3'd1, cmdw(8'h5A, 8, 8'h01));
    st(1, 1, m_eol, 1, 0, "R5 page write into locked sector");
    chk_word(32, "R5 locked page untouched");
    wr(3'd1, cmdw(8'h5A, 0, 8'h08));
    st(1, 1, m_eol, 1, 0, "R5 erase with a locked sector");
    st(1, 1, m_eol, 0, 0, "R6 lock error cleared by read");
    chk_word(20, "R5 erase aborted");
    do_cmd(8'h04, 11);
    st(1, 1, m_eol, 0, 0, "R9 unlock via page 11 clears sector 2");

    // R8 erase all
    do_cmd(8'h08, 0);
    chk_word(20, "R8 erase fills ones");
    chk_word(23, "R8 erase fills ones");

    // R11 security, R10 nvm clear / set
    do_cmd(8'h0F, 0);
    st(1, 1, m_eol, 0, 0, "R11 security set");
    do_cmd(8'h0D, 1);
    do_cmd(8'h0B, 2);
    do_cmd(8'h0B, 0);
    st(1, 1, m_eol, 0, 0, "R10 R11 nvm bits 0 and 2, security sticky");

    // R12 writes during busy, last busy cycle
    pb(32'hB000_0000); pb(32'hB000_0001); pb(32'hB000_0002); pb(32'hB000_0003);
    wr(3'd1, cmdw(8'h5A, 7, 8'h01));
    wr(3'd3, 32'hDEAD_BEEF);
    idle(2);
    wr(3'd1, cmdw(8'h5A, 0, 8'h02));
    for (int w = 0; w < 4; w++) m_mem[28 + w] = m_pbuf[w];
    m_pidx = 0;
    st(1, 1, m_eol, 0, 0, "R12 command in last busy cycle ignored");
    chk_word(28, "R12 page 7 word 0");
    chk_word(31, "R12 page 7 word 3");
    pb(32'hC000_0000); pb(32'hC000_0001); pb(32'hC000_0002); pb(32'hC000_0003);
    do_cmd(8'h01, 3);
    chk_word(12, "R12 R7 buffer slot 0 not hit while busy");
    chk_word(15, "R7 buffer index wrapped to slot 3");

    // R13 end-of-lock reporting
    wr(3'd1, cmdw(8'h5A, 0, 8'h02));
    st(0, 1, 0, 0, 0, "R13 lock busy: ready kept high, eol cleared");
    idle(3);
    m_lock[0] = 1'b1;
    st(1, 1, 1, 0, 0, "R13 eol set at lock end, default keeps bit1 low");
    wr(3'd1, cmdw(8'h5A, 1, 8'h04));
    st(0, 1, 0, 0, 0, "R13 unlock clears eol on accept");
    idle(3);
    m_lock[0] = 1'b0;
    st(1, 1, 1, 0, 0, "R13 eol set at unlock end");

    idle(2);
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule